// File: doc/BRIEF.md
# Interleaved Channel Offset Canceller

This block sits on the merged output of a time-interleaved converter with several sub-converters. Each incoming sample carries the index of the sub-converter that produced it. In steady rotation, channel i owns merged positions k·NCH + i. The block assumes the analog input has a mean of about zero. It works out each channel's DC offset in the background by averaging a block of 2^LOG2N samples from that channel. From then on it subtracts that channel's estimate from every later sample of the same channel. This is the first correction stage, ahead of any gain or skew correction.

Each channel has its own accumulator, sample counter and estimate register. The mean is taken with an arithmetic right shift, so no divider is needed. The accumulator is LOG2N bits wider than a sample, so a block of full-scale samples cannot overflow it. Until a channel finishes its first block, its estimate is zero and its samples pass through unchanged. After that, the estimate is replaced at the end of every block. The corrected sample is clamped to the sample range, so it never wraps.

Top module: `ilv_offset_cancel`

## Requirements
- R1: While rst_n is low and in the first cycle after it, out_valid is 0 and every bit of est_ready is 0.
- R2: While a channel has not completed a block, its corrected sample equals its raw sample.
- R3: out_data equals in_data minus the current estimate of the channel named by in_chan. Each channel's estimate depends only on that channel's own samples.
- R4: When a channel receives the last sample of a block of 2^LOG2N samples, its estimate becomes floor(block sum / 2^LOG2N), which rounds toward minus infinity. The block's last sample is still corrected with the previous estimate. The new estimate applies from that channel's next sample onward.
- R5: est_ready[i] is set in the cycle where the output of channel i's first completed block's last sample appears. It then stays set until reset, and it changes only in cycles that follow an accepted sample.
- R6: A difference above 2^(W-1)-1 is output as 2^(W-1)-1, and a difference below -2^(W-1) is output as -2^(W-1).
- R7: For each cycle with in_valid high, the next cycle has out_valid high and out_chan equal to that in_chan. Cycles with in_valid low give out_valid low in the next cycle.
- R8: A block made entirely of full-scale samples (all +2^(W-1)-1 or all -2^(W-1)) yields exactly that value as the estimate, with no accumulator overflow.
- R9: Cycles with in_valid low neither advance a channel's block count nor change its accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Raw sample present |
| in_chan | input | $clog2(NCH) | Channel index of the raw sample |
| in_data | input | W | Raw sample, two's complement |
| out_valid | output | 1 | Corrected sample present |
| out_chan | output | $clog2(NCH) | Channel index of the corrected sample |
| out_data | output | W | Corrected sample, two's complement, saturated |
| est_ready | output | NCH | Per-channel flag: estimate built from at least one block |

## Verification
The main stream uses a different offset on each channel, with zero-mean square and triangle patterns riding on it. A channel mixup or a shared estimate would therefore show up as wrong outputs on the other channels. One channel alternates 0 and -1, giving a block sum of -8, so the shift must round down to -1 rather than toward zero. Blocks of full-scale and near-full-scale samples followed by opposite-sign extremes exercise accumulator width and both saturation limits. Random idle gaps separate accepted samples, to show that only valid cycles advance the block count.

// File: rtl/ilv_offset_cancel.sv
module ilv_offset_cancel #(
  parameter int NCH   = 4,
  parameter int W     = 12,
  parameter int LOG2N = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [$clog2(NCH)-1:0] in_chan,
  input  logic signed [W-1:0]    in_data,
  output logic                   out_valid,
  output logic [$clog2(NCH)-1:0] out_chan,
  output logic signed [W-1:0]    out_data,
  output logic [NCH-1:0]         est_ready
);
  localparam int CW = $clog2(NCH);
  localparam int AW = W + LOG2N;
  localparam logic [LOG2N-1:0] LAST = {LOG2N{1'b1}};
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [AW-1:0] acc [NCH];
  logic [LOG2N-1:0]     cnt [NCH];
  logic signed [W-1:0]  est [NCH];

  logic signed [AW-1:0] acc_nxt;
  logic signed [AW-1:0] mean;
  logic signed [W:0]    diff;
  logic signed [W-1:0]  clamped;

  assign acc_nxt = acc[in_chan] + AW'(in_data);
  assign mean    = acc_nxt >>> LOG2N;
  assign diff    = {in_data[W-1], in_data} - {est[in_chan][W-1], est[in_chan]};
  assign clamped = (diff[W] == diff[W-1]) ? diff[W-1:0] : (diff[W] ? MINV : MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        acc[i] <= '0;
        cnt[i] <= '0;
        est[i] <= '0;
      end
      est_ready <= '0;
    end else if (in_valid) begin
      if (cnt[in_chan] == LAST) begin
        est[in_chan]       <= mean[W-1:0];
        acc[in_chan]       <= '0;
        est_ready[in_chan] <= 1'b1;
      end else begin
        acc[in_chan] <= acc_nxt;
      end
      cnt[in_chan] <= cnt[in_chan] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_chan <= in_chan;
        out_data <= clamped;
      end
    end
  end
endmodule

// File: rtl/ilv_offset_cancel_chk.sv
module ilv_offset_cancel_chk #(
  parameter int NCH = 4,
  parameter int W   = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [$clog2(NCH)-1:0] in_chan,
  input logic signed [W-1:0]    in_data,
  input logic                   out_valid,
  input logic [$clog2(NCH)-1:0] out_chan,
  input logic signed [W-1:0]    out_data,
  input logic [NCH-1:0]         est_ready
);
  p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_chan_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_chan == $past(in_chan));
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !est_ready[in_chan]) |=> out_data == $past(in_data));
  p_ready_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((est_ready & $past(est_ready)) == $past(est_ready)));
  p_ready_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(est_ready));
endmodule

bind ilv_offset_cancel ilv_offset_cancel_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
  .in_data(in_data), .out_valid(out_valid), .out_chan(out_chan),
  .out_data(out_data), .est_ready(est_ready)
);

// File: tb/ilv_offset_cancel_tb.sv
module ilv_offset_cancel_tb;
  localparam int NCH = 4;
  localparam int W = 12;
  localparam int LOG2N = 4;
  localparam int N = 1 << LOG2N;
  localparam int CW = $clog2(NCH);

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [CW-1:0] in_chan = '0;
  logic signed [W-1:0] in_data = '0;
  logic out_valid;
  logic [CW-1:0] out_chan;
  logic signed [W-1:0] out_data;
  logic [NCH-1:0] est_ready;

  int checks = 0;
  int fails = 0;

  int m_sum [NCH];
  int m_cnt [NCH];
  int m_est [NCH];
  bit m_rdy [NCH];

  int q_chan[$];
  int q_data[$];
  bit q_rdy[$];
  string q_req[$];

  always #2 clk = ~clk;

  ilv_offset_cancel #(.NCH(NCH), .W(W), .LOG2N(LOG2N)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .in_data(in_data), .out_valid(out_valid), .out_chan(out_chan),
    .out_data(out_data), .est_ready(est_ready)
  );

  function automatic int sat(int v);
    int hi = (1 << (W-1)) - 1;
    int lo = -(1 << (W-1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic int floordiv(int s);
    int q = s / N;
    if ((s % N) != 0 && s < 0) q = q - 1;
    return q;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int ch, int x, string req, int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 0;
    end
    @(negedge clk);
    in_valid = 1;
    in_chan = CW'(ch);
    in_data = W'(x);
    q_chan.push_back(ch);
    q_data.push_back(sat(x - m_est[ch]));
    q_req.push_back(req);
    m_sum[ch] += x;
    m_cnt[ch]++;
    if (m_cnt[ch] == N) begin
      m_est[ch] = floordiv(m_sum[ch]);
      m_sum[ch] = 0;
      m_cnt[ch] = 0;
      m_rdy[ch] = 1;
    end
    q_rdy.push_back(m_rdy[ch]);
  endtask

  task automatic idle(int n);
    for (int g = 0; g < n; g++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_chan.size() == 0) begin
        chk("R7 unexpected out_valid", 1, 0);
      end else begin
        automatic int ec = q_chan.pop_front();
        automatic int ed = q_data.pop_front();
        automatic bit er = q_rdy.pop_front();
        automatic string rq = q_req.pop_front();
        chk("R7 out_chan", int'(out_chan), ec);
        chk(rq, int'(out_data), ed);
        chk("R5 est_ready", int'(est_ready[ec]), int'(er));
      end
    end
  end

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_sum[c] = 0; m_cnt[c] = 0; m_est[c] = 0; m_rdy[c] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 est_ready in reset", int'(est_ready), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 est_ready after reset", int'(est_ready), 0);

    // R2 R3 R4 R9: distinct offsets, zero-mean patterns, random idle gaps
    for (int k = 0; k < 3 * N; k++) begin
      drive(0, 100 + ((k % 2) ? 30 : -30), "R2/R3 ch0", $urandom_range(0, 2));
      drive(1, -50 + ((k % 4) - 1) * 8 - 4, "R2/R3 ch1", $urandom_range(0, 1));
      drive(2, (k % 2) ? -1 : 0, "R4 floor ch2", 0);
      drive(3, -300 + ((k % 2) ? 200 : -200), "R3 ch3", $urandom_range(0, 3));
    end
    idle(5);
    chk("R9 est_ready after idle", int'(est_ready), 4'hf);

    // R6 R8: full-scale blocks then opposite extremes
    for (int k = 0; k < N; k++) begin
      drive(0, 2000, "R6 ch0 load", 0);
      drive(1, -2000, "R6 ch1 load", 0);
      drive(2, 2047, "R8 ch2 load", 0);
      drive(3, -2048, "R8 ch3 load", 0);
    end
    drive(0, -2048, "R6 saturate low", 0);
    drive(1, 2047, "R6 saturate high", 0);
    drive(2, 2047, "R8 full-scale positive", 0);
    drive(2, 0, "R8 full-scale positive", 0);
    drive(3, -2048, "R8 full-scale negative", 1);
    drive(3, 0, "R8 full-scale negative", 0);
    idle(4);
    chk("R7 queue drained", q_chan.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule